// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Model

This block is a clocked, synthesizable model of a 4096 x 1 dynamic memory. The storage is a matrix of 64 rows by 64 bits. A single 6-bit address bus carries the row address and then the column address. Active-low row strobe, column strobe and write-enable inputs are sampled on the system clock, and their edges are detected inside the block.

When the row strobe falls, the whole addressed row is copied into a row latch. Every column access works on that latch. When the row strobe rises, the latch is written back to the matrix. Within one row period, two column modes are available:
- **Page mode:** every column-strobe pulse samples a fresh column address.
- **Nibble mode:** only the first pulse samples a column. Later pulses step through the aligned group of four columns.

If the column strobe is already low when the row strobe falls, the cycle is a refresh. The row chosen by an internal pointer is read and written back, and the pointer then advances. A row-strobe cycle with no column pulse refreshes the row named on the bus.

The tri-state output is modelled as a data bit plus an enable flag. While `dout_oe_o` is low, the output counts as high-impedance and `dout_o` is held at 0.

Top module: `dram_mux_array`

## Requirements
- R1: After reset `dout_oe_o` and `dout_o` are 0 and the refresh pointer is 0.
- R2: A bit is addressed by a row (6 bits, taken from `addr_i` on the sample where `ras_ni` is first seen low) and a column (6 bits, taken from `addr_i` on the sample where `cas_ni` is first seen low while a row is open). Each of the 4096 row/column pairs holds its own bit.
- R3: A read is a column pulse with `we_ni` high. From the clock after `cas_ni` is sampled low, `dout_oe_o` is 1 and `dout_o` equals the addressed bit. From the clock after `cas_ni` is sampled high, `dout_oe_o` is 0.
- R4: A write is a column pulse with `we_ni` low. It replaces the addressed latch bit with `din_i` and keeps `dout_oe_o` at 0. The modified row reaches the matrix when `ras_ni` rises, so a later row period reads the new value back.
- R5: Within one row period, a read returns a value written by an earlier column pulse of the same period.
- R6: With `nibble_i` = 0 (page mode), every column pulse inside one row period samples a new column from `addr_i`.
- R7: With `nibble_i` = 1, only the first column pulse of a row period samples `addr_i`. Each later pulse adds 1 to the low two column bits, wrapping within the group of four, and leaves the upper four bits unchanged.
- R8: If `cas_ni` is already low when `ras_ni` falls, the cycle is a refresh.
  - The row named by the pointer is read and written back unchanged.
  - The pointer then increments, wrapping from 63 to 0.
  - Column pulses inside that row period are ignored, and `dout_oe_o` stays 0.
- R9: A row period with no column pulse leaves the addressed row unchanged.
- R10: A `cas_ni` fall sampled while `ras_ni` is high writes nothing and drives nothing. This includes a fall on the same sample as the `ras_ni` rise that closes a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Shared address bus: row on the row strobe, column on the column strobe |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low, sampled at the column strobe fall |
| din_i | input | 1 | Write data |
| nibble_i | input | 1 | 0 selects page mode, 1 selects nibble mode |
| dout_o | output | 1 | Read data; 0 while not enabled |
| dout_oe_o | output | 1 | Output enable; low means the output is high-impedance |

## Verification
The write-back on a row close and a column-strobe fall can occur on the same clock sample. The bench provokes this by raising `ras_ni` and lowering `cas_ni` (with `we_ni` low) in one drive step just after a write period. It then leaves `cas_ni` low and lowers `ras_ni` again, which turns the next period into a refresh. The result is judged at the ports:
- `dout_oe_o` must stay low throughout.
- A later read of the column that was on the bus must return the value from before the collision.

// File: rtl/dram_pkg.sv
package dram_pkg;
  localparam int unsigned ROW_W_DEF = 6;
  localparam int unsigned COL_W_DEF = 6;
  localparam int unsigned NIB_W_DEF = 2;
  localparam int unsigned STROBE_N  = 2;
  localparam int unsigned RAS_IDX   = 0;
  localparam int unsigned CAS_IDX   = 1;
endpackage

// File: rtl/dram_edge_det.sv
module dram_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] prev_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;  // strobes idle high
    else         prev_q <= sig_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall_o[i] = prev_q[i] & ~sig_i[i];
    assign rise_o[i] = ~prev_q[i] & sig_i[i];
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int unsigned ROW_W = 6,
  parameter int unsigned COL_W = 6
) (
  input  logic                  clk_i,
  input  logic [ROW_W-1:0]      rd_row_i,
  output logic [(1<<COL_W)-1:0] rd_data_o,
  input  logic                  wr_en_i,
  input  logic [ROW_W-1:0]      wr_row_i,
  input  logic [(1<<COL_W)-1:0] wr_data_i
);
  localparam int unsigned ROWS = 1 << ROW_W;
  localparam int unsigned COLS = 1 << COL_W;

  logic [COLS-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_row_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_row_i];
endmodule

// File: rtl/dram_col_ctrl.sv
module dram_col_ctrl #(
  parameter int unsigned COL_W = 6,
  parameter int unsigned NIB_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [(1<<COL_W)-1:0] load_data_i,
  input  logic                  close_i,
  input  logic                  active_i,
  input  logic                  cas_fall_i,
  input  logic                  cas_rise_i,
  input  logic                  we_ni,
  input  logic                  din_i,
  input  logic                  nibble_i,
  input  logic [COL_W-1:0]      col_i,
  output logic [(1<<COL_W)-1:0] row_data_o,
  output logic                  dout_o,
  output logic                  dout_oe_o
);
  localparam int unsigned COLS = 1 << COL_W;
  localparam logic [NIB_W-1:0] NIB_ONE = NIB_W'(1);

  logic [COLS-1:0]  row_q;
  logic [COL_W-1:0] col_q, col_nxt;
  logic             first_q, act_q, rd_q;
  logic             access;

  assign access = cas_fall_i & active_i & ~load_i;

  // nibble mode: later pulses step the low bits inside the aligned group
  always_comb begin
    if (nibble_i && !first_q)
      col_nxt = {col_q[COL_W-1:NIB_W], col_q[NIB_W-1:0] + NIB_ONE};
    else
      col_nxt = col_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      col_q   <= '0;
      first_q <= 1'b1;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
    end else if (load_i) begin
      row_q   <= load_data_i;
      first_q <= 1'b1;
      act_q   <= 1'b0;
    end else if (access) begin
      col_q   <= col_nxt;
      first_q <= 1'b0;
      act_q   <= 1'b1;
      rd_q    <= we_ni;
      if (!we_ni) row_q[col_nxt] <= din_i;
    end else if (cas_rise_i || close_i) begin
      act_q   <= 1'b0;
    end
  end

  assign dout_oe_o  = act_q & rd_q;
  assign dout_o     = dout_oe_o & row_q[col_q];
  assign row_data_o = row_q;

  assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !we_ni) |=> (row_q[col_q] == $past(din_i)));

  assert_nibble_group_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && nibble_i && !first_q) |=>
      (col_q[COL_W-1:NIB_W] == $past(col_q[COL_W-1:NIB_W])));

  assert_page_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !nibble_i) |=> (col_q == $past(col_i)));
endmodule

// File: rtl/dram_mux_array.sv
module dram_mux_array
  import dram_pkg::*;
#(
  parameter int unsigned ROW_W = ROW_W_DEF,
  parameter int unsigned COL_W = COL_W_DEF,
  parameter int unsigned NIB_W = NIB_W_DEF
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr_i,
  input  logic                                      ras_ni,
  input  logic                                      cas_ni,
  input  logic                                      we_ni,
  input  logic                                      din_i,
  input  logic                                      nibble_i,
  output logic                                      dout_o,
  output logic                                      dout_oe_o
);
  localparam int unsigned COLS = 1 << COL_W;

  logic [STROBE_N-1:0] strobes, prev, fall, rise;
  logic ras_fall, ras_rise, cas_fall, cas_rise, cas_prev, ras_prev;
  logic cbr_start, open_q, cbr_q, active;
  logic [ROW_W-1:0] row_q, ptr_q, rd_row;
  logic [COLS-1:0]  rd_data, wb_data;

  assign strobes[RAS_IDX] = ras_ni;
  assign strobes[CAS_IDX] = cas_ni;

  dram_edge_det #(.N(STROBE_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (strobes),
    .prev_o (prev),
    .fall_o (fall),
    .rise_o (rise)
  );

  assign ras_fall = fall[RAS_IDX];
  assign ras_rise = rise[RAS_IDX];
  assign cas_fall = fall[CAS_IDX];
  assign cas_rise = rise[CAS_IDX];
  assign cas_prev = prev[CAS_IDX];
  assign ras_prev = prev[RAS_IDX];

  // column strobe already low at row strobe fall: refresh cycle
  assign cbr_start = ras_fall & ~cas_prev;
  assign rd_row    = cbr_start ? ptr_q : addr_i[ROW_W-1:0];
  assign active    = open_q & ~cbr_q & ~ras_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cbr_q  <= 1'b0;
      row_q  <= '0;
      ptr_q  <= '0;
    end else if (ras_fall) begin
      open_q <= 1'b1;
      cbr_q  <= cbr_start;
      row_q  <= rd_row;
    end else if (ras_rise && open_q) begin
      open_q <= 1'b0;
      cbr_q  <= 1'b0;
      if (cbr_q) ptr_q <= ptr_q + 1'b1;
    end
  end

  dram_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk_i     (clk_i),
    .rd_row_i  (rd_row),
    .rd_data_o (rd_data),
    .wr_en_i   (ras_rise & open_q),
    .wr_row_i  (row_q),
    .wr_data_i (wb_data)
  );

  dram_col_ctrl #(.COL_W(COL_W), .NIB_W(NIB_W)) u_col (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ras_fall),
    .load_data_i (rd_data),
    .close_i     (ras_rise),
    .active_i    (active),
    .cas_fall_i  (cas_fall),
    .cas_rise_i  (cas_rise),
    .we_ni       (we_ni),
    .din_i       (din_i),
    .nibble_i    (nibble_i),
    .col_i       (addr_i[COL_W-1:0]),
    .row_data_o  (wb_data),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o)
  );

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q |-> !dout_oe_o);

  assert_open_tracks_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> !ras_prev);

  assert_oe_needs_cas_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> !cas_prev);

  assert_refresh_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_q |-> !dout_oe_o);

  assert_ptr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_rise && open_q && cbr_q) |=> (ptr_q == ROW_W'($past(ptr_q) + 1'b1)));

  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ras_rise && open_q && cbr_q) |=> $stable(ptr_q));

  assert_collision_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_fall && ras_ni) |=> !dout_oe_o);
endmodule

// File: tb/tb_dram_mux_array.sv
module tb_dram_mux_array;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {write, row, col, data}; for reads data is the expected bit
  localparam logic [13:0] VECS [NV] = '{
    {1'b1, 6'd5,  6'd9,  1'b1}, {1'b1, 6'd5,  6'd10, 1'b0},
    {1'b1, 6'd63, 6'd63, 1'b1}, {1'b1, 6'd0,  6'd0,  1'b1},
    {1'b1, 6'd0,  6'd63, 1'b0}, {1'b1, 6'd63, 6'd0,  1'b1},
    {1'b0, 6'd5,  6'd9,  1'b1}, {1'b0, 6'd5,  6'd10, 1'b0},
    {1'b0, 6'd63, 6'd63, 1'b1}, {1'b0, 6'd0,  6'd0,  1'b1},
    {1'b0, 6'd0,  6'd63, 1'b0}, {1'b0, 6'd63, 6'd0,  1'b1},
    {1'b1, 6'd5,  6'd9,  1'b0}, {1'b0, 6'd5,  6'd9,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0, nib = 1'b0;
  logic       dout, dout_oe;
  int         checks = 0, errors = 0, cycles = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_mux_array dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .din_i(din), .nibble_i(nib), .dout_o(dout), .dout_oe_o(dout_oe)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      finish_run();
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_row(input logic [5:0] r);
    addr = r; ras_n = 1'b0; step();
  endtask

  task automatic close_row();
    ras_n = 1'b1; step();
  endtask

  task automatic col_write(input logic [5:0] c, input logic d, input string req);
    addr = c; we_n = 1'b0; din = d; cas_n = 1'b0; step();
    check(req, dout_oe, 0);
    cas_n = 1'b1; we_n = 1'b1; step();
  endtask

  task automatic col_read(input logic [5:0] c, input logic exp, input string req);
    addr = c; we_n = 1'b1; cas_n = 1'b0; step();
    check(req, dout_oe, 1);
    check(req, dout, exp);
    cas_n = 1'b1; step();
    check(req, dout_oe, 0);
  endtask

  task automatic wr_bit(input logic [5:0] r, input logic [5:0] c, input logic d, input string req);
    open_row(r); col_write(c, d, req); close_row();
  endtask

  task automatic rd_bit(input logic [5:0] r, input logic [5:0] c, input logic exp, input string req);
    open_row(r); col_read(c, exp, req); close_row();
  endtask

  task automatic cbr_cycle(input bool_pulse);
    cas_n = 1'b0; step();
    ras_n = 1'b0; step();
    check("R8 refresh output off", dout_oe, 0);
    if (bool_pulse) begin
      cas_n = 1'b1; step();
      addr = 6'd0; we_n = 1'b0; din = 1'b0; cas_n = 1'b0; step();
      check("R8 pulse ignored in refresh", dout_oe, 0);
      we_n = 1'b1;
    end
    cas_n = 1'b1; step();
    ras_n = 1'b1; step();
  endtask

  initial begin
    step(); step();
    check("R1 reset oe", dout_oe, 0);
    check("R1 reset dout", dout, 0);
    rst_n = 1'b1; step();
    check("R1 idle oe", dout_oe, 0);

    // R2/R3/R4: vector table of single accesses
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][13]) wr_bit(VECS[i][12:7], VECS[i][6:1], VECS[i][0], "R4 table write");
      else             rd_bit(VECS[i][12:7], VECS[i][6:1], VECS[i][0], "R2 R3 table read");
    end

    // R5/R6: page mode writes then reads in one row period
    nib = 1'b0;
    wr_bit(6'd10, 6'd8, 1'b1, "R4 setup");
    open_row(6'd10);
    col_write(6'd3, 1'b1, "R6 page write");
    col_write(6'd4, 1'b0, "R6 page write");
    col_read(6'd3, 1'b1, "R5 latch read-after-write");
    col_read(6'd4, 1'b0, "R5 latch read-after-write");
    col_read(6'd8, 1'b1, "R6 page read");
    close_row();
    rd_bit(6'd10, 6'd3, 1'b1, "R4 write-back");

    // R7: nibble mode writes, later pulses carry a junk address
    wr_bit(6'd20, 6'd8, 1'b1, "R7 neighbour setup");
    nib = 1'b1;
    open_row(6'd20);
    col_write(6'd6, 1'b1, "R7 nibble write");
    col_write(6'd63, 1'b0, "R7 nibble write");
    col_write(6'd63, 1'b1, "R7 nibble write");
    col_write(6'd63, 1'b0, "R7 nibble write");
    close_row();
    nib = 1'b0;
    rd_bit(6'd20, 6'd6, 1'b1, "R7 col 6");
    rd_bit(6'd20, 6'd7, 1'b0, "R7 col 7");
    rd_bit(6'd20, 6'd4, 1'b1, "R7 wrap col 4");
    rd_bit(6'd20, 6'd5, 1'b0, "R7 col 5");
    rd_bit(6'd20, 6'd8, 1'b1, "R7 outside group");
    nib = 1'b1;
    open_row(6'd20);
    col_read(6'd5, 1'b0, "R7 nibble read col 5");
    col_read(6'd0, 1'b1, "R7 nibble read col 6");
    col_read(6'd0, 1'b0, "R7 nibble read col 7");
    col_read(6'd0, 1'b1, "R7 nibble read col 4");
    col_read(6'd0, 1'b0, "R7 nibble read col 5 again");
    close_row();
    nib = 1'b0;

    // R8: refresh cycles, first one with an ignored write pulse, then a full pointer wrap
    cbr_cycle(1'b1);
    rd_bit(6'd0, 6'd0, 1'b1, "R8 refresh keeps data");
    for (int i = 0; i < 64; i++) cbr_cycle(1'b0);
    rd_bit(6'd5, 6'd9, 1'b0, "R8 after wrap");
    rd_bit(6'd63, 6'd63, 1'b1, "R8 after wrap");
    rd_bit(6'd20, 6'd6, 1'b1, "R8 after wrap");

    // R9: row-only cycle
    open_row(6'd63); close_row();
    rd_bit(6'd63, 6'd0, 1'b1, "R9 row-only keeps data");

    // R10: column fall on the same sample as the row close, then refresh
    open_row(6'd5);
    col_write(6'd10, 1'b0, "R10 setup");
    addr = 6'd9; we_n = 1'b0; din = 1'b1; ras_n = 1'b1; cas_n = 1'b0; step();
    check("R10 collision oe", dout_oe, 0);
    ras_n = 1'b0; step();
    check("R10 following refresh oe", dout_oe, 0);
    we_n = 1'b1; cas_n = 1'b1; step();
    ras_n = 1'b1; step();
    rd_bit(6'd5, 6'd9, 1'b0, "R10 collision wrote nothing");

    // R10: stray column pulse with no row open
    addr = 6'd9; we_n = 1'b0; din = 1'b1; cas_n = 1'b0; step();
    check("R10 stray pulse oe", dout_oe, 0);
    cas_n = 1'b1; we_n = 1'b1; step();
    rd_bit(6'd5, 6'd9, 1'b0, "R10 stray pulse wrote nothing");

    done = 1'b1;
    finish_run();
  end
endmodule